// File: doc/BRIEF.md
# Video Sync Lock Status Filter

This block turns a raw, noisy sync-lock indication from a video front end into a stable locked/unlocked status. It evaluates the raw condition once per video line, on a single-cycle line strobe. It declares lock only after the condition has held for a programmed run of consecutive lines. It declares loss of lock only after the opposite condition has held for a separately programmed run.

Two raw lock candidates are offered. One is a fast per-line check of the horizontal sync timing window. The other is a slower free-running check that looks over several fields. A select input picks one of them. An enable input can also require that the colour subcarrier loop reports lock. The two run lengths are each chosen by a 3-bit code from a fixed, roughly logarithmic table that reaches 100,000 lines.

Top module: `vid_lock_filter`

## Requirements
- R1: While reset is asserted and after its release, `locked_o` is 0 and `status_o` is 2'b00 until the first qualifying line strobe.
- R2: In the unlocked state, `locked_o` rises on the strobe that completes N consecutive strobes on which the condition is true. N comes from `enter_code`: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000.
- R3: In the locked state, `locked_o` falls on the strobe that completes N consecutive strobes on which the condition is false. N comes from `leave_code` through the same table as R2.
- R4: A strobe whose condition does not oppose the current state clears the run, so the count must start again from zero.
- R5: State, run count and `status_o` change only on clock edges where `line_stb` is 1. Raw inputs that toggle between strobes have no effect.
- R6: With `src_sel` = 0 the condition is taken from `raw_frun`. With `src_sel` = 1 it is taken from `raw_twin`.
- R7: With `fsc_en` = 0 the condition is the selected raw signal alone. With `fsc_en` = 1 the condition is the selected raw signal AND `fsc_lock`.
- R8: `status_o[0]` equals the filtered lock state. `status_o[1]` holds the condition sampled at the most recent strobe.
- R9: A new count code is used from the next strobe on. If the run already reaches or exceeds a lowered threshold, the state switches on that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| raw_twin | input | 1 | Line-based sync window lock |
| raw_frun | input | 1 | Field-based free-run lock |
| fsc_lock | input | 1 | Colour subcarrier lock flag |
| src_sel | input | 1 | Raw source select (0 free-run, 1 window) |
| fsc_en | input | 1 | Require subcarrier lock |
| enter_code | input | 3 | Run-length code to enter lock |
| leave_code | input | 3 | Run-length code to leave lock |
| locked_o | output | 1 | Filtered lock state |
| status_o | output | 2 | {sampled condition, lock state} |

## Verification
Two things can happen on the same strobe: a count code is rewritten, and the run reaches its threshold. When the threshold is lowered below a run already under way, the state must switch at once. The bench provokes this directly by building a 50-line run against the 100-line code and then switching to the 5-line code just before one more strobe. It also provokes it at random, by changing both codes while strobes and raw inputs vary. Each outcome is judged against a bench model that applies the table to the run length counted so far.

// File: rtl/lock_filt_pkg.sv
package lock_filt_pkg;
  localparam int unsigned RUN_W = 17;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_st_e;

  function automatic logic [RUN_W-1:0] code_to_lines(input logic [2:0] code);
    logic [RUN_W-1:0] n;
    case (code)
      3'd0:    n = RUN_W'(1);
      3'd1:    n = RUN_W'(2);
      3'd2:    n = RUN_W'(5);
      3'd3:    n = RUN_W'(10);
      3'd4:    n = RUN_W'(100);
      3'd5:    n = RUN_W'(500);
      3'd6:    n = RUN_W'(1000);
      default: n = RUN_W'(100000);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/lock_cond_sel.sv
module lock_cond_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_twin,
  input  logic raw_frun,
  input  logic fsc_lock,
  input  logic src_sel,
  input  logic fsc_en,
  output logic cond_o
);
  logic raw_pick;

  always_comb begin
    raw_pick = src_sel ? raw_twin : raw_frun;
    cond_o   = raw_pick & (fsc_lock | ~fsc_en);
  end

  // R7: with the subcarrier gate enabled and no subcarrier lock, the condition is never true
  p_fsc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsc_en && !fsc_lock) |-> !cond_o);

  // R6: a deselected source alone cannot raise the condition
  p_src_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !raw_twin) || (!src_sel && !raw_frun) |-> !cond_o);
endmodule

// File: rtl/lock_thresh_lut.sv
module lock_thresh_lut
  import lock_filt_pkg::*;
#(
  parameter int unsigned N_SEL = 2
) (
  input  logic [N_SEL*3-1:0]     code_i,
  output logic [N_SEL*RUN_W-1:0] lines_o
);
  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    always_comb lines_o[g*RUN_W +: RUN_W] = code_to_lines(code_i[g*3 +: 3]);
  end
endmodule

// File: rtl/lock_hyst_fsm.sv
module lock_hyst_fsm
  import lock_filt_pkg::*;
#(
  parameter int unsigned CW = RUN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          cond_i,
  input  logic [CW-1:0] enter_lines,
  input  logic [CW-1:0] leave_lines,
  output logic          locked_o,
  output logic          cond_seen_o
);
  localparam logic [CW-1:0] RUN_MAX = CW'(100000);

  lock_st_e      st_q, st_d;
  logic [CW-1:0] run_q, run_d;
  logic          seen_q, seen_d;
  logic          opposing;
  logic [CW-1:0] thr;
  logic [CW-1:0] run_inc;
  logic          hit;

  always_comb begin
    opposing = (st_q == ST_LOCKED) ? ~cond_i : cond_i;
    thr      = (st_q == ST_LOCKED) ? leave_lines : enter_lines;
    run_inc  = run_q + CW'(1);
    hit      = (run_inc >= thr);
    st_d     = st_q;
    run_d    = run_q;
    seen_d   = seen_q;
    if (line_stb) begin
      seen_d = cond_i;
      if (!opposing) begin
        run_d = '0;
      end else if (hit) begin
        st_d  = (st_q == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
        run_d = '0;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_UNLOCKED;
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (line_stb) begin
      st_q   <= st_d;
      run_q  <= run_d;
      seen_q <= seen_d;
    end
  end

  assign locked_o    = (st_q == ST_LOCKED);
  assign cond_seen_o = seen_q;

  // R5: nothing moves without a line strobe
  p_hold_no_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(st_q) && $stable(run_q) && $stable(seen_q));

  // R4: a non-opposing strobe leaves the run empty
  p_run_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !opposing) |=> (run_q == '0));

  // R2: the run never grows to the largest table entry without a switch
  p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_MAX);

  // R2: a completed entry run locks on that edge
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !locked_o && cond_i && (run_q + CW'(1) >= enter_lines)) |=> locked_o);

  // R3: a completed leave run unlocks on that edge
  p_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && locked_o && !cond_i && (run_q + CW'(1) >= leave_lines)) |=> !locked_o);

  // R8: the reported condition follows the one sampled at the strobe
  p_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> (cond_seen_o == $past(cond_i)));
endmodule

// File: rtl/vid_lock_filter.sv
module vid_lock_filter
  import lock_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       raw_twin,
  input  logic       raw_frun,
  input  logic       fsc_lock,
  input  logic       src_sel,
  input  logic       fsc_en,
  input  logic [2:0] enter_code,
  input  logic [2:0] leave_code,
  output logic       locked_o,
  output logic [1:0] status_o
);
  localparam int unsigned N_SEL = 2;

  logic                   rst_n_s;
  logic                   cond;
  logic [N_SEL*RUN_W-1:0] lines;
  logic                   seen;
  logic                   locked;

  lock_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lock_cond_sel u_cond (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .raw_twin (raw_twin),
    .raw_frun (raw_frun),
    .fsc_lock (fsc_lock),
    .src_sel  (src_sel),
    .fsc_en   (fsc_en),
    .cond_o   (cond)
  );

  lock_thresh_lut #(.N_SEL(N_SEL)) u_lut (
    .code_i  ({leave_code, enter_code}),
    .lines_o (lines)
  );

  lock_hyst_fsm #(.CW(RUN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .line_stb    (line_stb),
    .cond_i      (cond),
    .enter_lines (lines[0 +: RUN_W]),
    .leave_lines (lines[RUN_W +: RUN_W]),
    .locked_o    (locked),
    .cond_seen_o (seen)
  );

  assign locked_o = locked;
  assign status_o = {seen, locked};

  // R1: the block is unlocked while held in reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n_s |-> (status_o == 2'b00));
endmodule

// File: tb/tb_vid_lock_filter.sv
module tb_vid_lock_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_stb, raw_twin, raw_frun, fsc_lock, src_sel, fsc_en;
  logic [2:0] enter_code, leave_code;
  logic       locked_o;
  logic [1:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit m_lock;
  int m_run;
  bit m_seen;

  always #5 clk = ~clk;

  vid_lock_filter dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
    .raw_twin(raw_twin), .raw_frun(raw_frun), .fsc_lock(fsc_lock),
    .src_sel(src_sel), .fsc_en(fsc_en),
    .enter_code(enter_code), .leave_code(leave_code),
    .locked_o(locked_o), .status_o(status_o)
  );

  function automatic int lines_of(input bit [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 5;
      3'd3: return 10;
      3'd4: return 100;
      3'd5: return 500;
      3'd6: return 1000;
      default: return 100000;
    endcase
  endfunction

  function automatic bit cond_of(input bit s, input bit tw, input bit fr,
                                 input bit fe, input bit fl);
    bit r;
    r = s ? tw : fr;
    return r & (fl | ~fe);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 1'b0; m_run = 0; m_seen = 1'b0;
    end else if (line_stb) begin
      bit c;
      int thr;
      c = cond_of(src_sel, raw_twin, raw_frun, fsc_en, fsc_lock);
      m_seen = c;
      thr = m_lock ? lines_of(leave_code) : lines_of(enter_code);
      if (c == m_lock) m_run = 0;
      else if (m_run + 1 >= thr) begin m_lock = ~m_lock; m_run = 0; end
      else m_run = m_run + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // n consecutive strobes, one per cycle; returns at a falling edge
  task automatic lines(input int n);
    line_stb = 1'b1;
    repeat (n) @(negedge clk);
    line_stb = 1'b0;
  endtask

  task automatic set_raw(input bit tw, input bit fr, input bit fl);
    raw_twin = tw; raw_frun = fr; fsc_lock = fl;
  endtask

  initial begin
    #1900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0; line_stb = 1'b0; set_raw(0, 0, 0);
    src_sel = 1'b0; fsc_en = 1'b0; enter_code = 3'd4; leave_code = 3'd4;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 status after reset", int'(status_o), 0);

    // R2: two-line entry
    enter_code = 3'd1; set_raw(0, 1, 0);
    lines(1);
    chk("R2 not yet locked after 1 of 2", int'(locked_o), 0);
    chk("R8 sampled condition bit", int'(status_o[1]), 1);
    lines(1);
    chk("R2 locked after 2 of 2", int'(locked_o), 1);
    chk("R8 status after lock", int'(status_o), 3);

    // R5: toggling raw inputs between strobes does nothing
    for (int i = 0; i < 20; i++) begin
      set_raw(i[0], i[1], i[2]);
      @(negedge clk);
    end
    chk("R5 state held without strobes", int'(status_o), 3);

    // R4 / R3: five-line exit broken by one good line
    leave_code = 3'd2; set_raw(0, 0, 0);
    lines(4);
    raw_frun = 1'b1; lines(1);
    chk("R4 run broken, still locked", int'(locked_o), 1);
    raw_frun = 1'b0; lines(4);
    chk("R4 restarted run 4 of 5", int'(locked_o), 1);
    lines(1);
    chk("R3 unlocked after 5 of 5", int'(locked_o), 0);
    chk("R8 status after unlock", int'(status_o), 0);

    // R6: source selection
    enter_code = 3'd0; src_sel = 1'b0; set_raw(1, 0, 0);
    lines(3);
    chk("R6 window ignored when free-run selected", int'(locked_o), 0);
    src_sel = 1'b1; lines(1);
    chk("R6 window used when selected", int'(locked_o), 1);

    // R7: subcarrier gate
    leave_code = 3'd0; fsc_en = 1'b1; set_raw(1, 1, 0);
    lines(1);
    chk("R7 gate drops lock without subcarrier", int'(locked_o), 0);
    chk("R7 condition bit gated", int'(status_o[1]), 0);
    fsc_lock = 1'b1; lines(1);
    chk("R7 lock with both", int'(locked_o), 1);
    fsc_en = 1'b0; fsc_lock = 1'b0; leave_code = 3'd3; lines(3);
    chk("R7 gate off, subcarrier ignored", int'(locked_o), 1);

    // R3: ten-line exit boundary
    set_raw(0, 0, 0);
    lines(9);
    chk("R3 9 of 10 still locked", int'(locked_o), 1);
    lines(1);
    chk("R3 10 of 10 unlocked", int'(locked_o), 0);

    // R9: lowered threshold during a run
    enter_code = 3'd4; src_sel = 1'b0; raw_frun = 1'b1;
    lines(50);
    chk("R9 50 of 100 unlocked", int'(locked_o), 0);
    enter_code = 3'd2; lines(1);
    chk("R9 lowered code switches at once", int'(locked_o), 1);

    // R2: 100-line boundary
    leave_code = 3'd0; raw_frun = 1'b0; lines(1);
    enter_code = 3'd4; raw_frun = 1'b1;
    lines(99);
    chk("R2 99 of 100", int'(locked_o), 0);
    lines(1);
    chk("R2 100 of 100", int'(locked_o), 1);

    // R2: longest code
    raw_frun = 1'b0; lines(1);
    chk("R3 one-line exit", int'(locked_o), 0);
    enter_code = 3'd7; raw_frun = 1'b1;
    lines(99999);
    chk("R2 99999 of 100000", int'(locked_o), 0);
    lines(1);
    chk("R2 100000 of 100000", int'(locked_o), 1);

    // random mix, compared with the model every cycle
    for (int i = 0; i < 4000; i++) begin
      line_stb = ($urandom % 3) != 0;
      set_raw($urandom % 4 != 0, $urandom % 4 != 0, $urandom % 5 != 0);
      if ($urandom % 8 == 0) src_sel = $urandom % 2;
      if ($urandom % 16 == 0) fsc_en = $urandom % 2;
      if ($urandom % 12 == 0) enter_code = 3'($urandom % 4);
      if ($urandom % 12 == 0) leave_code = 3'($urandom % 4);
      @(negedge clk);
      chk("R2/R3/R9 random lock vs model", int'(locked_o), int'(m_lock));
      chk("R8 random status bit vs model", int'(status_o[1]), int'(m_seen));
    end
    line_stb = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule